// File: doc/BRIEF.md
# Conversion result threshold monitor

This block sits behind a converter's decimation filter and post-processes its stream of 24-bit results. Each result arrives with a one-cycle valid strobe. A result is read as unsigned (unipolar) or as two's complement, depending on a control bit. The block keeps the most recent qualifying result in a data register guarded by a ready flag. It can thin the ready interrupt by counting results against a programmed limit. It compares the magnitude of every result against a 16-bit threshold, and a saturating exceedance counter debounces that comparison before a level flag is raised. It also sums the results into a 32-bit accumulator and checks that sum against its own 32-bit threshold.

Software configures and observes the block through a simple synchronous register bus, with single-cycle write and read strobes and a combinational read data path. The hold logic is a two-state machine. It rests in HOLD_EMPTY. It takes the LATCH transition to HOLD_FULL when a qualifying result is captured. It takes the DRAIN transition back to HOLD_EMPTY when software reads the data register. A calibration-done input sets a sticky status bit, and a write to the mode register clears that bit.

Register addresses: 0 control (bit0 enable, bit1 two's complement, bit2 result-count mode, bit3 up/down exceedance mode), 1 mode word (bits 3:0), 2 data (read, bits 23:0), 3 status (bit0 ready, bit1 level flag, bit2 accumulator flag, bit3 calibration done; writing 1 to bit1 or bit2 clears that flag), 4 result limit (15:0), 5 magnitude threshold (15:0), 6 exceedance limit (7:0), 7 accumulator threshold (31:0), 8 accumulator (read).

Top module: `result_monitor`

## Requirements
- R1: A qualifying result that arrives while ready is clear is stored in the data register (address 2) and sets ready (status bit0, irq_ready). While ready stays set, no later result changes the data register.
- R2: A read strobe at address 2 clears ready on the following edge. A qualifying result that arrives in the same cycle as that read, while ready is still set, is dropped.
- R3: With result-count mode off (control bit2 = 0), every accepted result qualifies. With it on, each accepted result advances a counter, and only the result that brings the count to the result limit (address 4) qualifies. The counter then restarts at 0.
- R4: Any write to the control or mode register returns the result counter to 0. A result that arrives in the same cycle as such a write is discarded by every function.
- R5: In unipolar mode the raw result is compared against all 16 threshold bits. In two's complement mode (control bit1 = 1) the absolute value is compared against threshold bits 14:0 only. A result counts as exceeding when its magnitude is greater than or equal to the threshold.
- R6: The exceedance counter increments, saturating at 255, on each exceeding result. On a result below threshold it decrements, saturating at 0, in up/down mode (control bit3 = 1), and clears to 0 in up/reset mode. A control write clears it.
- R7: The level flag (status bit1, irq_level) sets when the exceedance count after an accepted result is at least the exceedance limit. It stays set until a 1 is written to status bit1, and a set in the same cycle wins over the clear.
- R8: The accumulator adds each accepted result (sign-extended in two's complement mode, zero-extended otherwise), wraps modulo 2^32, reads at address 8, and clears on a control write. The accumulator flag (status bit2, irq_accum) sets when the new sum (its absolute value in two's complement mode) is at least the accumulator threshold, and it clears on writing 1 to status bit2.
- R9: A cal_done pulse sets status bit3. A write to the mode register clears it, and the clear wins if both happen in the same cycle.
- R10: With control bit0 = 0, results are ignored. No data, counter, accumulator or flag changes.
- R11: After reset every register, counter, flag and output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | One-cycle strobe marking a new result |
| res_data | input | 24 | Conversion result |
| cal_done | input | 1 | Pulse: calibration cycle finished |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| irq_ready | output | 1 | Ready flag |
| irq_level | output | 1 | Magnitude exceedance flag |
| irq_accum | output | 1 | Accumulator exceedance flag |

## Verification
Results are driven just below, at, and just above the threshold in both number formats. Threshold values with bit 15 set separate the 16-bit compare from the 15-bit compare, and negative inputs separate a true absolute value from a raw compare. Alternating runs of exceeding and quiet results separate up/down counting from up/reset counting and expose the saturation at zero. Collisions of a result with a data read, a control or mode write, or a flag clear pin down which event wins in each case. A long run of full-scale values drives the accumulator through its 32-bit wrap.

// File: rtl/resmon_pkg.sv
package resmon_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 4'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 4'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd3;
    localparam logic [ADDR_W-1:0] A_RLIM = 4'd4;
    localparam logic [ADDR_W-1:0] A_THR  = 4'd5;
    localparam logic [ADDR_W-1:0] A_XLIM = 4'd6;
    localparam logic [ADDR_W-1:0] A_ATHR = 4'd7;
    localparam logic [ADDR_W-1:0] A_ACC  = 4'd8;

    typedef enum logic [0:0] {
        HOLD_EMPTY = 1'b0,
        HOLD_FULL  = 1'b1
    } hold_state_e;

    typedef struct packed {
        logic updown;
        logic cnt_mode;
        logic twos;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/resmon_regs.sv
module resmon_regs
    import resmon_pkg::*;
#(
    parameter int THR_W  = 16,
    parameter int ACC_W  = 32,
    parameter int RCNT_W = 16,
    parameter int XCNT_W = 8,
    parameter int MODE_W = 4,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              cal_done,
    output ctrl_t             ctrl_q,
    output logic [MODE_W-1:0] mode_q,
    output logic [RCNT_W-1:0] rlim_q,
    output logic [THR_W-1:0]  thr_q,
    output logic [XCNT_W-1:0] xlim_q,
    output logic [ACC_W-1:0]  athr_q,
    output logic              cal_q,
    output logic              ctrl_wr,
    output logic              cfg_wr,
    output logic              data_rd,
    output logic              lvl_clr,
    output logic              acc_clr
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic mode_wr;

    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign mode_wr = bus_wr && (bus_addr == A_MODE);
    assign cfg_wr  = ctrl_wr || mode_wr;
    assign data_rd = bus_rd && (bus_addr == A_DATA);
    assign lvl_clr = bus_wr && (bus_addr == A_STAT) && bus_wdata[1];
    assign acc_clr = bus_wr && (bus_addr == A_STAT) && bus_wdata[2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
            rlim_q <= '0;
            thr_q  <= '0;
            xlim_q <= '0;
            athr_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL:  ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
                A_MODE:  mode_q <= bus_wdata[MODE_W-1:0];
                A_RLIM:  rlim_q <= bus_wdata[RCNT_W-1:0];
                A_THR:   thr_q  <= bus_wdata[THR_W-1:0];
                A_XLIM:  xlim_q <= bus_wdata[XCNT_W-1:0];
                A_ATHR:  athr_q <= bus_wdata[ACC_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        cal_q <= 1'b0;
        else if (mode_wr)  cal_q <= 1'b0;
        else if (cal_done) cal_q <= 1'b1;
    end

    p_cal_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MODE) |=> !cal_q);
    p_cal_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && !(bus_wr && bus_addr == A_MODE)) |=> cal_q);
endmodule

// File: rtl/resmon_hold.sv
module resmon_hold
    import resmon_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int RCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] res,
    input  logic              cnt_mode,
    input  logic [RCNT_W-1:0] rlim,
    input  logic              cnt_clr,
    input  logic              data_rd,
    output logic              ready,
    output logic [DATA_W-1:0] data_q
);
    hold_state_e       state_q, state_d;
    logic [RCNT_W-1:0] cnt_q;
    logic [RCNT_W:0]   cnt_inc;
    logic              hit;
    logic              capture;

    assign cnt_inc = {1'b0, cnt_q} + (RCNT_W+1)'(1);
    assign hit     = !cnt_mode || (cnt_inc == {1'b0, rlim});

    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (cnt_clr)          cnt_q <= '0;
        else if (take && cnt_mode) cnt_q <= hit ? '0 : cnt_inc[RCNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HOLD_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            HOLD_EMPTY: if (take && hit) begin
                state_d = HOLD_FULL;
                capture = 1'b1;
            end
            HOLD_FULL: if (data_rd) state_d = HOLD_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (capture) data_q <= res;
    end

    always_comb ready = (state_q == HOLD_FULL);

    p_hold_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !data_rd) |=> ($stable(data_q) && ready));
    p_read_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && data_rd) |=> !ready);
    p_no_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !(take && hit)) |=> !ready);
    p_cnt_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt_q == '0));
endmodule

// File: rtl/resmon_level.sv
module resmon_level #(
    parameter int DATA_W = 24,
    parameter int THR_W  = 16,
    parameter int XCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] res,
    input  logic              twos,
    input  logic              updown,
    input  logic [THR_W-1:0]  thr,
    input  logic [XCNT_W-1:0] xlim,
    input  logic              cnt_clr,
    input  logic              flag_clr,
    output logic              flag_q
);
    localparam logic [XCNT_W-1:0] XMAX = '1;

    logic [DATA_W-1:0] mag;
    logic [THR_W-1:0]  thr_eff;
    logic              over;
    logic [XCNT_W-1:0] xcnt_q, xnext;

    assign mag     = (twos && res[DATA_W-1]) ? (~res + DATA_W'(1)) : res;
    assign thr_eff = twos ? {1'b0, thr[THR_W-2:0]} : thr;
    assign over    = mag >= {{(DATA_W-THR_W){1'b0}}, thr_eff};

    always_comb begin
        if (over)        xnext = (xcnt_q != XMAX) ? xcnt_q + XCNT_W'(1) : XMAX;
        else if (updown) xnext = (xcnt_q != '0) ? xcnt_q - XCNT_W'(1) : '0;
        else             xnext = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       xcnt_q <= '0;
        else if (cnt_clr) xcnt_q <= '0;
        else if (take)    xcnt_q <= xnext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                     flag_q <= 1'b0;
        else if (take && xnext >= xlim) flag_q <= 1'b1;
        else if (flag_clr)              flag_q <= 1'b0;
    end

    p_count_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && over && xcnt_q != XMAX) |=> (xcnt_q == $past(xcnt_q) + XCNT_W'(1)));
    p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !over && xcnt_q == '0) |=> (xcnt_q == '0));
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
    p_twos_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (twos && !res[DATA_W-1] && res < DATA_W'(thr[THR_W-2:0])) |-> !over);
endmodule

// File: rtl/resmon_accum.sv
module resmon_accum #(
    parameter int DATA_W = 24,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] res,
    input  logic              twos,
    input  logic [ACC_W-1:0]  athr,
    input  logic              clr,
    input  logic              flag_clr,
    output logic [ACC_W-1:0]  acc_q,
    output logic              flag_q
);
    logic [ACC_W-1:0] ext, acc_n, amag;

    assign ext   = twos ? {{(ACC_W-DATA_W){res[DATA_W-1]}}, res}
                        : {{(ACC_W-DATA_W){1'b0}}, res};
    assign acc_n = acc_q + ext;
    assign amag  = (twos && acc_n[ACC_W-1]) ? (~acc_n + ACC_W'(1)) : acc_n;

    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (clr)  acc_q <= '0;
        else if (take) acc_q <= acc_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                   flag_q <= 1'b0;
        else if (take && amag >= athr) flag_q <= 1'b1;
        else if (flag_clr)            flag_q <= 1'b0;
    end

    p_acc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clr) |=> $stable(acc_q));
    p_acc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));
    p_aflag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/result_monitor.sv
module result_monitor
    import resmon_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int THR_W  = 16,
    parameter int ACC_W  = 32,
    parameter int RCNT_W = 16,
    parameter int XCNT_W = 8,
    parameter int MODE_W = 4,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              cal_done,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_ready,
    output logic              irq_level,
    output logic              irq_accum
);
    ctrl_t             ctrl_q;
    logic [MODE_W-1:0] mode_q;
    logic [RCNT_W-1:0] rlim_q;
    logic [THR_W-1:0]  thr_q;
    logic [XCNT_W-1:0] xlim_q;
    logic [ACC_W-1:0]  athr_q, acc_q;
    logic [DATA_W-1:0] data_q;
    logic cal_q, ctrl_wr, cfg_wr, data_rd, lvl_clr, acc_clr, take;

    assign take = res_valid && ctrl_q.en && !cfg_wr;

    resmon_regs #(.THR_W(THR_W), .ACC_W(ACC_W), .RCNT_W(RCNT_W), .XCNT_W(XCNT_W),
                  .MODE_W(MODE_W), .BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cal_done(cal_done),
        .ctrl_q(ctrl_q), .mode_q(mode_q), .rlim_q(rlim_q), .thr_q(thr_q),
        .xlim_q(xlim_q), .athr_q(athr_q), .cal_q(cal_q), .ctrl_wr(ctrl_wr),
        .cfg_wr(cfg_wr), .data_rd(data_rd), .lvl_clr(lvl_clr), .acc_clr(acc_clr));

    resmon_hold #(.DATA_W(DATA_W), .RCNT_W(RCNT_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .take(take), .res(res_data),
        .cnt_mode(ctrl_q.cnt_mode), .rlim(rlim_q), .cnt_clr(cfg_wr),
        .data_rd(data_rd), .ready(irq_ready), .data_q(data_q));

    resmon_level #(.DATA_W(DATA_W), .THR_W(THR_W), .XCNT_W(XCNT_W)) u_level (
        .clk(clk), .rst_n(rst_n), .take(take), .res(res_data), .twos(ctrl_q.twos),
        .updown(ctrl_q.updown), .thr(thr_q), .xlim(xlim_q), .cnt_clr(ctrl_wr),
        .flag_clr(lvl_clr), .flag_q(irq_level));

    resmon_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .take(take), .res(res_data), .twos(ctrl_q.twos),
        .athr(athr_q), .clr(ctrl_wr), .flag_clr(acc_clr), .acc_q(acc_q),
        .flag_q(irq_accum));

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = BUS_W'(ctrl_q);
            A_MODE:  bus_rdata = BUS_W'(mode_q);
            A_DATA:  bus_rdata = BUS_W'(data_q);
            A_STAT:  bus_rdata = BUS_W'({cal_q, irq_accum, irq_level, irq_ready});
            A_RLIM:  bus_rdata = BUS_W'(rlim_q);
            A_THR:   bus_rdata = BUS_W'(thr_q);
            A_XLIM:  bus_rdata = BUS_W'(xlim_q);
            A_ATHR:  bus_rdata = BUS_W'(athr_q);
            A_ACC:   bus_rdata = BUS_W'(acc_q);
            default: bus_rdata = '0;
        endcase
    end

    p_ignore_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !ctrl_q.en && !bus_wr && !bus_rd)
        |=> ($stable(acc_q) && $stable(irq_ready) && $stable(irq_level) && $stable(irq_accum)));
    p_cfg_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && bus_wr && bus_addr == A_CTRL) |=> (acc_q == '0));
endmodule

// File: tb/test_result_monitor.sv
module test_result_monitor;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [23:0] res_data = '0;
    logic        cal_done = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_ready, irq_level, irq_accum;

    result_monitor i_result_monitor (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .cal_done(cal_done), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ready(irq_ready),
        .irq_level(irq_level), .irq_accum(irq_accum));

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string cur_req = "R11";

    // behavioural reference state
    logic        m_en = 0, m_twos = 0, m_cnt = 0, m_ud = 0;
    logic [3:0]  m_mode = 0;
    logic [15:0] m_rlim = 0, m_thr = 0;
    logic [7:0]  m_xlim = 0;
    logic [31:0] m_athr = 0;
    logic        m_ready = 0, m_lf = 0, m_af = 0, m_cal = 0;
    logic [23:0] m_data = 0;
    int          m_rc = 0, m_xc = 0;
    longint      m_acc = 0;
    longint      v, mag, thr_e, amag;
    bit          take, cw, hit;

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_en, m_twos, m_cnt, m_ud} = '0;
            m_mode = 0; m_rlim = 0; m_thr = 0; m_xlim = 0; m_athr = 0;
            m_ready = 0; m_lf = 0; m_af = 0; m_cal = 0; m_data = 0;
            m_rc = 0; m_xc = 0; m_acc = 0;
        end else begin
            cw   = bus_wr && (bus_addr == 4'd0 || bus_addr == 4'd1);
            take = res_valid && m_en && !cw;
            hit  = 0;
            amag = 0;
            if (take) begin
                v = longint'(res_data);
                if (m_twos && res_data[23]) v = v - 64'sd16777216;
                mag   = (v < 0) ? -v : v;
                thr_e = m_twos ? longint'(m_thr[14:0]) : longint'(m_thr);
                if (mag >= thr_e)  m_xc = (m_xc < 255) ? m_xc + 1 : 255;
                else if (m_ud)     m_xc = (m_xc > 0) ? m_xc - 1 : 0;
                else               m_xc = 0;
                m_acc = (m_acc + v + 64'sd4294967296) % 64'sd4294967296;
                amag  = (m_twos && m_acc >= 64'sd2147483648) ? 64'sd4294967296 - m_acc : m_acc;
                hit = 1;
                if (m_cnt) begin
                    m_rc = m_rc + 1;
                    if (m_rc == int'(m_rlim)) m_rc = 0;
                    else begin hit = 0; m_rc = m_rc % 65536; end
                end
            end
            if (!m_ready) begin
                if (take && hit) begin m_ready = 1; m_data = res_data; end
            end else if (bus_rd && bus_addr == 4'd2) m_ready = 0;
            if (take && m_xc >= int'(m_xlim)) m_lf = 1;
            else if (bus_wr && bus_addr == 4'd3 && bus_wdata[1]) m_lf = 0;
            if (take && amag >= longint'(m_athr)) m_af = 1;
            else if (bus_wr && bus_addr == 4'd3 && bus_wdata[2]) m_af = 0;
            if (bus_wr && bus_addr == 4'd1) m_cal = 0;
            else if (cal_done) m_cal = 1;
            if (bus_wr) begin
                case (bus_addr)
                    4'd0: begin {m_ud, m_cnt, m_twos, m_en} = bus_wdata[3:0];
                                m_rc = 0; m_xc = 0; m_acc = 0; end
                    4'd1: begin m_mode = bus_wdata[3:0]; m_rc = 0; end
                    4'd4: m_rlim = bus_wdata[15:0];
                    4'd5: m_thr  = bus_wdata[15:0];
                    4'd6: m_xlim = bus_wdata[7:0];
                    4'd7: m_athr = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            4'd0: return {28'b0, m_ud, m_cnt, m_twos, m_en};
            4'd1: return {28'b0, m_mode};
            4'd2: return {8'b0, m_data};
            4'd3: return {28'b0, m_cal, m_af, m_lf, m_ready};
            4'd4: return {16'b0, m_rlim};
            4'd5: return {16'b0, m_thr};
            4'd6: return {24'b0, m_xlim};
            4'd7: return m_athr;
            4'd8: return 32'(m_acc);
            default: return 32'b0;
        endcase
    endfunction

    task automatic chk(input string sig, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, sig, act, exp, $time);
        end
    endtask

    // compare on every clock, between edges
    always @(negedge clk) begin
        #3;
        chk("irq_ready", {31'b0, irq_ready}, {31'b0, m_ready});
        chk("irq_level", {31'b0, irq_level}, {31'b0, m_lf});
        chk("irq_accum", {31'b0, irq_accum}, {31'b0, m_af});
        chk($sformatf("bus_rdata@%0d", bus_addr), bus_rdata, exp_rd(bus_addr));
    end

    task automatic cyc(input logic v_i, input logic [23:0] d, input logic w, input logic r,
                       input logic [3:0] a, input logic [31:0] wd, input logic c);
        @(negedge clk);
        res_valid = v_i; res_data = d; bus_wr = w; bus_rd = r;
        bus_addr = a; bus_wdata = wd; cal_done = c;
    endtask
    task automatic wr(input logic [3:0] a, input logic [31:0] d); cyc(0, 0, 1, 0, a, d, 0); endtask
    task automatic rd(input logic [3:0] a); cyc(0, 0, 0, 1, a, 0, 0); endtask
    task automatic peek(input logic [3:0] a); cyc(0, 0, 0, 0, a, 0, 0); endtask
    task automatic res(input logic [23:0] d); cyc(1, d, 0, 0, 4'd3, 0, 0); endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        peek(4'd3); peek(4'd8); peek(4'd2); peek(4'd0);

        // R10: block disabled, results ignored
        cur_req = "R10";
        res(24'd7); res(24'd9); peek(4'd8); peek(4'd2); peek(4'd3);

        wr(4'd5, 32'd100); wr(4'd6, 32'd2); wr(4'd7, 32'd300); wr(4'd0, 32'h1);

        // R1: capture and hold
        cur_req = "R1";
        res(24'd50); res(24'd60); peek(4'd2);
        // R2: read clears ready, collision drops result
        cur_req = "R2";
        rd(4'd2); peek(4'd3); res(24'd70); cyc(1, 24'd80, 0, 1, 4'd2, 0, 0);
        peek(4'd2); res(24'd90); peek(4'd2); rd(4'd2);

        // R5: magnitude compare in both formats
        cur_req = "R5";
        wr(4'd6, 32'd1); wr(4'd3, 32'h6);
        res(24'd99); peek(4'd3); res(24'd100); peek(4'd3); wr(4'd3, 32'h2);
        wr(4'd5, 32'h8010); res(24'h00800F); peek(4'd3); res(24'h008010); wr(4'd3, 32'h2);
        wr(4'd0, 32'h3); res(24'h00000F); peek(4'd3); res(24'hFFFFF1); peek(4'd3);
        res(24'hFFFFF0); peek(4'd3); wr(4'd3, 32'h2); res(24'h000010); peek(4'd3);

        // R6: exceedance counter modes
        cur_req = "R6";
        wr(4'd5, 32'd20); wr(4'd0, 32'hB); wr(4'd6, 32'd3); wr(4'd3, 32'h6);
        res(24'd30); res(24'd30); res(24'd5); res(24'd5); res(24'd5); res(24'd30);
        res(24'd30); res(24'd30); peek(4'd3);
        wr(4'd3, 32'h2); wr(4'd0, 32'h3);
        res(24'd30); res(24'd30); res(24'd1); res(24'd30); res(24'd30); peek(4'd3);

        // R7: level flag set and write-one-to-clear, set wins
        cur_req = "R7";
        wr(4'd6, 32'd2); wr(4'd3, 32'h2);
        res(24'd40); res(24'd40); peek(4'd3); wr(4'd3, 32'h2); peek(4'd3);
        res(24'd40); cyc(1, 24'd40, 1, 0, 4'd3, 32'h2, 0); peek(4'd3); wr(4'd3, 32'h2);

        // R8: accumulator, its flag and the wrap
        cur_req = "R8";
        wr(4'd0, 32'h1); wr(4'd7, 32'h02FF_FFFF); wr(4'd3, 32'h4);
        res(24'hFFFFFF); res(24'hFFFFFF); peek(4'd8); res(24'hFFFFFF); peek(4'd3);
        wr(4'd3, 32'h4); peek(4'd3);
        wr(4'd0, 32'h3); wr(4'd7, 32'd100); res(24'hFFFF00); peek(4'd8); peek(4'd3);
        wr(4'd3, 32'h4); wr(4'd0, 32'h1); wr(4'd7, 32'hFFFF_FFFF);
        for (int i = 0; i < 260; i++) res(24'hFFFFFF);
        peek(4'd8); peek(4'd3);

        // R3: result-count mode
        cur_req = "R3";
        wr(4'd4, 32'd3); wr(4'd0, 32'h5); rd(4'd2);
        res(24'd1); res(24'd2); peek(4'd2); res(24'd3); peek(4'd2); rd(4'd2);
        res(24'd4); res(24'd5); res(24'd6); peek(4'd2); rd(4'd2);

        // R4: counter reset by control/mode write, colliding result discarded
        cur_req = "R4";
        res(24'd7); wr(4'd1, 32'h5); res(24'd8); res(24'd9); peek(4'd3);
        res(24'd10); peek(4'd2); rd(4'd2);
        res(24'd11); cyc(1, 24'd12, 1, 0, 4'd0, 32'h5, 0); peek(4'd8);
        res(24'd13); res(24'd14); peek(4'd3); res(24'd15); peek(4'd2); rd(4'd2);

        // R9: calibration status
        cur_req = "R9";
        cyc(0, 0, 0, 0, 4'd3, 0, 1); peek(4'd3); wr(4'd1, 32'h2); peek(4'd3);
        cyc(0, 0, 0, 0, 4'd3, 0, 1); cyc(0, 0, 1, 0, 4'd1, 32'h3, 1); peek(4'd3);

        // R3: back to every-result mode
        cur_req = "R3";
        wr(4'd0, 32'h1); res(24'd21); peek(4'd2); rd(4'd2); res(24'd22); peek(4'd2);

        peek(4'd3); peek(4'd3);
        @(negedge clk); #4;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule